// File: doc/BRIEF.md
# Constant-Current LED Sink Serial Register Core

This block is the digital core of a sixteen-channel LED sink driver. A serial word enters on `sdi`, one bit per rising clock edge, and moves along a shift chain. The last stage of the chain drives `sdo`, so several devices can be cascaded. A storage stage keeps the word that drives the channel controls. It refreshes from the chain while the latch control `le` is high and holds while `le` is low. The on/off pattern reaches the sixteen channel controls only while the active-low enable `oe_n` is low.

The block also saves power on its own. While the stored word contains no 1 bit, the block raises `shutdown` and turns every channel off. The first stored 1 bit releases the power-saving state again, and the block starts in this state after reset. The transparent latch is modelled inside one clock domain: on every clock edge at which `le` is high, the storage stage loads the chain contents as they stood just before that edge.

Top module: `led_sink_core`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, the chain and the stored word are zero, so `sdo` is 0, `shutdown` is 1 and `chan_on` is all zeros.
- R2: Each rising edge shifts `sdi` into chain bit 0 and moves bit i to bit i+1. `sdo` shows chain bit 15, so after a word w has been fed MSB first, `sdo` is w[15]. After k further edges it is w[15-k].
- R3: At an edge with `le` high, the stored word takes the value the chain held just before that edge.
- R4: At an edge with `le` low, the stored word is unchanged, even while new bits are shifting.
- R5: With `oe_n` low and `shutdown` low, `chan_on[i]` is 1 exactly when stored bit i is 1.
- R6: With `oe_n` high, `chan_on` is all zeros, and the stored word is kept and reappears when `oe_n` returns low.
- R7: `shutdown` is 1 whenever the stored word is all zeros, and `chan_on` is then all zeros.
- R8: `shutdown` falls as soon as any single stored bit is 1, including bit 0 alone and bit 15 alone.
- R9: With `le` held high across several edges, `chan_on` follows the chain with a lag of one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and system clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch control, level-sensitive, active high |
| oe_n | input | 1 | Output enable, active low |
| sdo | output | 1 | Serial data out, last chain stage |
| chan_on | output | 16 | Channel on controls |
| shutdown | output | 1 | Power-saving state flag |

## Verification
`sdo` changes one edge after the bit that moves it into the last stage. The stored word, and so `chan_on` and `shutdown`, changes at the edge where `le` is sampled high, while `oe_n` acts on `chan_on` in the same cycle without a register. The bench drives inputs at falling edges and samples at the following falling edge, which is one full register stage after each stimulus. For the combinational enable path it samples a short delay after `oe_n` changes. In the transparent case the bench keeps its own model of the chain and expects `chan_on` to equal the model from before the latest edge.

// File: rtl/led_sink_core.sv
module led_sink_core #(
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdi,
  input  logic          le,
  input  logic          oe_n,
  output logic          sdo,
  output logic [CH-1:0] chan_on,
  output logic          shutdown
);

  logic [CH-1:0] chain_q;
  logic [CH-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[CH-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (le) begin
      store_q <= chain_q;
    end
  end

  assign sdo      = chain_q[CH-1];
  assign shutdown = ~|store_q;
  assign chan_on  = (oe_n || shutdown) ? '0 : store_q;

endmodule

module led_sink_core_chk #(
  parameter int CH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          le,
  input logic          oe_n,
  input logic          sdo,
  input logic [CH-1:0] chain_q,
  input logic [CH-1:0] store_q,
  input logic [CH-1:0] chan_on,
  input logic          shutdown
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (shutdown && !sdo && chan_on == '0));

  assert_sdo_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sdo == $past(chain_q[CH-2]));

  assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> store_q == $past(chain_q));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> $stable(store_q));

  assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> chan_on == '0);

  assert_saving_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> chan_on == '0);

  assert_active_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !shutdown) |-> chan_on != '0);

endmodule

bind led_sink_core led_sink_core_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .le(le), .oe_n(oe_n), .sdo(sdo),
  .chain_q(chain_q), .store_q(store_q), .chan_on(chan_on), .shutdown(shutdown)
);

// File: tb/led_sink_core_tb.sv
module led_sink_core_tb;
  localparam int CH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0;
  logic le = 1'b0;
  logic oe_n = 1'b1;
  logic sdo;
  logic [CH-1:0] chan_on;
  logic shutdown;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [CH-1:0] model;

  always #2 clk = ~clk;

  led_sink_core #(.CH(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .le(le), .oe_n(oe_n),
    .sdo(sdo), .chan_on(chan_on), .shutdown(shutdown)
  );

  task automatic check(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [CH-1:0] w);
    for (int i = CH - 1; i >= 0; i--) begin
      sdi = w[i];
      @(negedge clk);
    end
    model = w;
  endtask

  task automatic latch_pulse();
    le = 1'b1;
    sdi = 1'b0;
    @(negedge clk);
    le = 1'b0;
    model = {model[CH-2:0], 1'b0};
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 sdo", {15'd0, sdo}, 16'd0);
    check("R1 shutdown", {15'd0, shutdown}, 16'd1);
    oe_n = 1'b0; #0.5;
    check("R1 chan_on", chan_on, 16'd0);
    oe_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 shutdown after release", {15'd0, shutdown}, 16'd1);
  endtask

  task automatic t_load_and_shift();
    logic [CH-1:0] w;
    w = 16'hA5C3;
    shift_word(w);
    check("R2 sdo msb", {15'd0, sdo}, {15'd0, w[15]});
    latch_pulse();
    oe_n = 1'b0; #0.5;
    check("R3 R5 chan_on", chan_on, w);
    check("R8 shutdown low", {15'd0, shutdown}, 16'd0);
    for (int k = 1; k < 6; k++) begin
      check("R2 sdo chain", {15'd0, sdo}, {15'd0, w[15-k]});
      sdi = 1'b1;
      @(negedge clk);
    end
    check("R4 held while shifting", chan_on, w);
    oe_n = 1'b1; #0.5;
    check("R6 blanked", chan_on, 16'd0);
    @(negedge clk);
    oe_n = 1'b0; #0.5;
    check("R6 word kept", chan_on, w);
  endtask

  task automatic t_zero_word();
    shift_word(16'h0000);
    latch_pulse();
    #0.5;
    check("R7 shutdown", {15'd0, shutdown}, 16'd1);
    check("R7 chan_on off", chan_on, 16'd0);
  endtask

  task automatic t_single_bits();
    shift_word(16'h0001);
    latch_pulse();
    #0.5;
    check("R8 bit0 shutdown", {15'd0, shutdown}, 16'd0);
    check("R8 bit0 chan_on", chan_on, 16'h0001);
    shift_word(16'h8000);
    latch_pulse();
    #0.5;
    check("R8 bit15 chan_on", chan_on, 16'h8000);
  endtask

  task automatic t_transparent();
    logic [CH-1:0] prev;
    shift_word(16'h3C01);
    le = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sdi = i[0];
      prev = model;
      @(negedge clk);
      model = {model[CH-2:0], i[0]};
      check("R9 follows chain", chan_on, prev);
    end
    le = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model = '0;
    @(negedge clk);
    t_reset();
    t_load_and_shift();
    t_zero_word();
    t_single_bits();
    t_transparent();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule